// File: doc/BRIEF.md
# Multi-Port Asynchronous-Read Word Memory

This block is a small storage array built from logic rather than from a dedicated memory macro. Writes are taken on the rising edge of the write clock. Every readable port is purely combinational: its data output follows its address with no clock involved. A compile-time parameter picks one of four port arrangements. All four arrangements use one write port and read the same array.

The `MODE` parameter has four values. `PM_SINGLE` has one combined read/write port. `PM_DUAL` adds one read-only port. `PM_SIMPLE` has a write-only port and one separate read port. `PM_QUAD` has one read/write port and three independent read-only ports. The port list is the same in every mode. Address inputs that a mode does not use are ignored, and data outputs that a mode does not use are held at zero. The array starts filled with zeros and has no reset.

Top module: `lutram_mp`

## Requirements
- R1: A word is stored at `addr_a` on a rising edge of `clk` only when `wr_en` is 1. With `wr_en` at 0, an edge leaves every location unchanged.
- R2: Each readable output shows the word at its own address combinationally. A new address gives new data in the same cycle, with no clock edge in between.
- R3: After an edge that writes address X, every readable port addressing X shows the new word straight away. Before that edge, the same ports show the previous word.
- R4: Every location reads 0 until it is first written.
- R5: With `MODE` = `PM_SINGLE`, `rdata_a` reads the word at `addr_a`, which is also the write address. `rdata_b`, `rdata_c` and `rdata_d` are 0.
- R6: With `MODE` = `PM_DUAL`, `rdata_a` reads at `addr_a` and `rdata_b` reads at `addr_b`. `rdata_c` and `rdata_d` are 0.
- R7: With `MODE` = `PM_SIMPLE`, the write port has no data output, so `rdata_a` is 0. `rdata_b` reads at `addr_b`, and `rdata_c` and `rdata_d` are 0.
- R8: With `MODE` = `PM_QUAD`, `rdata_a` through `rdata_d` read at `addr_a` through `addr_d`, each independently. Ports that address the same location see the same word.
- R9: When the same address is written on two back-to-back edges, the word from the second edge is the one kept.
- R10: All `DEPTH` locations (default 64, addresses 0 to 63) are distinct. Writing value i to address i for every i reads back as i on every readable port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock, rising edge |
| wr_en | input | 1 | Write enable, active high |
| addr_a | input | AW (6) | Write address, and read address of port A |
| wdata | input | WIDTH (8) | Write data |
| addr_b | input | AW (6) | Read address of port B |
| addr_c | input | AW (6) | Read address of port C |
| addr_d | input | AW (6) | Read address of port D |
| rdata_a | output | WIDTH (8) | Combinational read data of port A |
| rdata_b | output | WIDTH (8) | Combinational read data of port B |
| rdata_c | output | WIDTH (8) | Combinational read data of port C |
| rdata_d | output | WIDTH (8) | Combinational read data of port D |

## Verification
The hardest case to reach from the ports is the cycle where a write is pending while the read ports already address the target location. The old word must stay visible up to the edge, and the new word must appear immediately after it. The bench reaches this case by holding every read address on the write address across the write edge, then sampling once before the edge and once after it. Four instances, one per mode, share the same stimulus, so a single sequence of vectors checks every port arrangement against one behavioural reference.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

  typedef enum logic [1:0] {
    PM_SINGLE = 2'd0,
    PM_DUAL   = 2'd1,
    PM_SIMPLE = 2'd2,
    PM_QUAD   = 2'd3
  } port_mode_e;

  localparam int NUM_RD = 4;

  // Which of the four read outputs (index 0 = A .. 3 = D) a mode drives.
  function automatic logic port_readable(port_mode_e m, int idx);
    case (m)
      PM_SINGLE: return (idx == 0);
      PM_DUAL:   return (idx <= 1);
      PM_SIMPLE: return (idx == 1);
      default:   return 1'b1;
    endcase
  endfunction

  // Mask of readable ports for a mode.
  function automatic logic [NUM_RD-1:0] readable_mask(port_mode_e m);
    logic [NUM_RD-1:0] mk;
    for (int i = 0; i < NUM_RD; i++) mk[i] = port_readable(m, i);
    return mk;
  endfunction

  // An address selects a real word only below the depth.
  function automatic logic addr_in_range(int unsigned a, int unsigned depth);
    return (a < depth);
  endfunction

endpackage

// File: rtl/lutram_wr_ctrl.sv
module lutram_wr_ctrl #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic             wr_fire,
  output logic [AW-1:0]    wr_addr,
  output logic [WIDTH-1:0] wr_word
);
  import lutram_pkg::*;

  assign wr_fire = wr_en && addr_in_range(int'(addr), DEPTH);
  assign wr_addr = addr;
  assign wr_word = wdata;

endmodule

// File: rtl/lutram_store.sv
module lutram_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  parameter int NRD   = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      wr_fire,
  input  logic [AW-1:0]             wr_addr,
  input  logic [WIDTH-1:0]          wr_word,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][WIDTH-1:0] rword
);
  import lutram_pkg::*;

  logic [WIDTH-1:0] mem [DEPTH] = '{default: '0};

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_addr] <= wr_word;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_fetch
    always_comb begin
      if (addr_in_range(int'(raddr[p]), DEPTH)) rword[p] = mem[raddr[p]];
      else rword[p] = '0;
    end
  end

  // Record of the most recent write, kept only for the checks below.
  logic             lw_valid = 1'b0;
  logic [AW-1:0]    lw_addr  = '0;
  logic [WIDTH-1:0] lw_word  = '0;

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      lw_valid <= 1'b1;
      lw_addr  <= wr_addr;
      lw_word  <= wr_word;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_chk
    always_comb begin
      if (lw_valid && raddr[p] == lw_addr)
        assert_fresh_write_R3: assert (rword[p] == lw_word);
      if (!lw_valid)
        assert_clean_start_R4: assert (rword[p] == '0);
    end
  end

endmodule

// File: rtl/lutram_rd_port.sv
module lutram_rd_port #(
  parameter int   WIDTH  = 8,
  parameter logic ENABLE = 1'b1
) (
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] rdata
);
  if (ENABLE) begin : g_live
    assign rdata = word;
  end else begin : g_tied
    assign rdata = '0;
  end
endmodule

// File: rtl/lutram_mp.sv
module lutram_mp #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  parameter lutram_pkg::port_mode_e MODE = lutram_pkg::PM_QUAD,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr_a,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    addr_b,
  input  logic [AW-1:0]    addr_c,
  input  logic [AW-1:0]    addr_d,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b,
  output logic [WIDTH-1:0] rdata_c,
  output logic [WIDTH-1:0] rdata_d
);
  import lutram_pkg::*;

  localparam logic [NUM_RD-1:0] RD_MASK = readable_mask(MODE);

  logic             wr_fire;
  logic [AW-1:0]    wr_addr;
  logic [WIDTH-1:0] wr_word;

  logic [NUM_RD-1:0][AW-1:0]    raddr;
  logic [NUM_RD-1:0][WIDTH-1:0] rword;
  logic [NUM_RD-1:0][WIDTH-1:0] rdata;

  assign raddr[0] = addr_a;
  assign raddr[1] = addr_b;
  assign raddr[2] = addr_c;
  assign raddr[3] = addr_d;

  lutram_wr_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_wr (
    .wr_en   (wr_en),
    .addr    (addr_a),
    .wdata   (wdata),
    .wr_fire (wr_fire),
    .wr_addr (wr_addr),
    .wr_word (wr_word)
  );

  lutram_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NRD(NUM_RD)) u_store (
    .clk     (clk),
    .wr_fire (wr_fire),
    .wr_addr (wr_addr),
    .wr_word (wr_word),
    .raddr   (raddr),
    .rword   (rword)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    lutram_rd_port #(.WIDTH(WIDTH), .ENABLE(RD_MASK[p])) u_port (
      .word  (rword[p]),
      .rdata (rdata[p])
    );
  end

  assign rdata_a = rdata[0];
  assign rdata_b = rdata[1];
  assign rdata_c = rdata[2];
  assign rdata_d = rdata[3];

  // A write enable at 0 keeps the port-A word across the edge (R1).
  logic          prev_we   = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [WIDTH-1:0] prev_word = '0;
  logic          prev_ok   = 1'b0;
  always_ff @(posedge clk) begin
    prev_we   <= wr_en;
    prev_addr <= addr_a;
    prev_word <= rword[0];
    prev_ok   <= 1'b1;
  end

  always_comb begin
    for (int p = 0; p < NUM_RD; p++) begin
      if (!RD_MASK[p])
        assert_unused_quiet_R7: assert (rdata[p] == '0);
    end
    if (MODE == PM_QUAD && addr_b == addr_c)
      assert_port_agree_R8: assert (rdata_b == rdata_c);
    if (prev_ok && !prev_we && addr_a == prev_addr)
      assert_hold_no_write_R1: assert (rword[0] == prev_word);
  end

endmodule

// File: tb/test_lutram_mp.sv
`timescale 1ns/1ps
module test_lutram_mp;
  import lutram_pkg::*;

  localparam int DEPTH = 64;
  localparam int WIDTH = 8;
  localparam int AW    = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             wr_en = 1'b0;
  logic [AW-1:0]    addr_a = '0, addr_b = '0, addr_c = '0, addr_d = '0;
  logic [WIDTH-1:0] wdata = '0;

  logic [WIDTH-1:0] q_s [4], q_d [4], q_p [4], q_q [4];

  lutram_mp #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MODE(PM_QUAD)) i_lutram_mp (
    .clk(clk), .wr_en(wr_en), .addr_a(addr_a), .wdata(wdata),
    .addr_b(addr_b), .addr_c(addr_c), .addr_d(addr_d),
    .rdata_a(q_q[0]), .rdata_b(q_q[1]), .rdata_c(q_q[2]), .rdata_d(q_q[3]));
  lutram_mp #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MODE(PM_SINGLE)) i_lutram_mp_single (
    .clk(clk), .wr_en(wr_en), .addr_a(addr_a), .wdata(wdata),
    .addr_b(addr_b), .addr_c(addr_c), .addr_d(addr_d),
    .rdata_a(q_s[0]), .rdata_b(q_s[1]), .rdata_c(q_s[2]), .rdata_d(q_s[3]));
  lutram_mp #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MODE(PM_DUAL)) i_lutram_mp_dual (
    .clk(clk), .wr_en(wr_en), .addr_a(addr_a), .wdata(wdata),
    .addr_b(addr_b), .addr_c(addr_c), .addr_d(addr_d),
    .rdata_a(q_d[0]), .rdata_b(q_d[1]), .rdata_c(q_d[2]), .rdata_d(q_d[3]));
  lutram_mp #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MODE(PM_SIMPLE)) i_lutram_mp_simple (
    .clk(clk), .wr_en(wr_en), .addr_a(addr_a), .wdata(wdata),
    .addr_b(addr_b), .addr_c(addr_c), .addr_d(addr_d),
    .rdata_a(q_p[0]), .rdata_b(q_p[1]), .rdata_c(q_p[2]), .rdata_d(q_p[3]));

  // Behavioural reference: a plain integer array updated on write edges.
  int ref_mem [DEPTH];
  initial for (int i = 0; i < DEPTH; i++) ref_mem[i] = 0;
  always @(posedge clk) if (wr_en) ref_mem[addr_a] = wdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(string tag, string port, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, port, act, exp);
    end
  endtask

  // Expected output of one port: readable modes see the array, others 0.
  function automatic int expect_out(int mode, int port, int a);
    bit live;
    case (mode)
      0: live = (port == 0);             // single
      1: live = (port == 0 || port == 1);// dual
      2: live = (port == 1);             // simple dual
      default: live = 1'b1;              // quad
    endcase
    return live ? ref_mem[a] : 0;
  endfunction

  task automatic compare_all(string tag);
    int ad [4];
    ad[0] = addr_a; ad[1] = addr_b; ad[2] = addr_c; ad[3] = addr_d;
    for (int p = 0; p < 4; p++) begin
      chk({tag, "/R5"}, $sformatf("single[%0d]", p), q_s[p], expect_out(0, p, ad[p]));
      chk({tag, "/R6"}, $sformatf("dual[%0d]", p),   q_d[p], expect_out(1, p, ad[p]));
      chk({tag, "/R7"}, $sformatf("simple[%0d]", p), q_p[p], expect_out(2, p, ad[p]));
      chk({tag, "/R8"}, $sformatf("quad[%0d]", p),   q_q[p], expect_out(3, p, ad[p]));
    end
  endtask

  // Drive right after a falling edge, check mid low phase, wait for next fall.
  task automatic apply(string tag, bit we, int a, int d, int b, int c, int e);
    wr_en = we; addr_a = AW'(a); wdata = WIDTH'(d);
    addr_b = AW'(b); addr_c = AW'(c); addr_d = AW'(e);
    #2;
    compare_all(tag);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R4: untouched array reads zero on every port.
    for (int i = 0; i < DEPTH; i++)
      apply("R4", 0, i, 8'hFF, (i + 1) % DEPTH, (i + 2) % DEPTH, (i + 3) % DEPTH);
    // R10: value i into address i, reads compared at the same time (R2).
    for (int i = 0; i < DEPTH; i++)
      apply("R10", 1, i, i, (i + 5) % DEPTH, (i + 9) % DEPTH, (DEPTH - 1 - i));
    // R10/R2: read back with address patterns changing every cycle.
    for (int i = 0; i < DEPTH; i++)
      apply("R2", 0, i, 0, DEPTH - 1 - i, (i + 7) % DEPTH, (i * 5) % DEPTH);
    // R1: enable low with fresh data must leave contents alone.
    for (int i = 0; i < 8; i++)
      apply("R1", 0, i * 3, 8'hEE, i * 3, i * 3, i * 3);
    for (int i = 0; i < 8; i++)
      apply("R1", 0, i * 3, 0, (i * 3 + 1) % DEPTH, i * 3, 0);
    // R3: old word before the edge, new word right after, all ports aimed.
    apply("R3", 1, 20, 8'hC3, 20, 20, 20);
    apply("R3", 0, 20, 0, 20, 20, 20);
    // R9: back-to-back rewrites of one address, last one kept.
    apply("R9", 1, 10, 8'hAA, 10, 10, 10);
    apply("R9", 1, 10, 8'h55, 10, 10, 10);
    apply("R9", 0, 10, 0, 10, 10, 10);
    apply("R9", 0, 11, 0, 10, 9, 10);
    // R8: all ports on the same location, then on distinct ones.
    apply("R8", 1, 63, 8'h7E, 63, 63, 63);
    apply("R8", 0, 63, 0, 63, 63, 63);
    apply("R8", 0, 0, 0, 63, 20, 10);
    apply("R8", 0, 63, 0, 0, 10, 20);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule